// File: doc/BRIEF.md
# Eight-Bit Timer and Watchdog with a Shared Divider

The block holds an eight-bit timer/counter and a watchdog counter that take turns owning one eight-bit divider. A bit in the option register hands the divider to one of them. Given to the timer, the divider sits in front of it as a prescaler. Given to the watchdog, it sits after the watchdog's base counter as a postscaler. The other owner then runs undivided.

The timer counts one of two sources. The first is the internal instruction clock, which is one pulse in every four clocks of a four-phase cycle. The second is an edge on an external pin. The pin is synchronized and then sampled on two of the four phases.

Writes to the timer and the watchdog-clear strobe reset the divider. Which of the two has that effect depends on who owns the divider at the time. Software sees only the timer value, the option register, a sticky overflow flag and a one-cycle watchdog reset pulse.

Top module: `tmr_shared_div`

## Requirements
- R1: After reset the option register reads 8'hFF, the timer reads 0, the overflow flag is 0 and the watchdog reset output is 0.
- R2: A phase counter steps 0,1,2,3 on each clock after reset. With bit 5 of the option register at 0, the timer source gives one event in each cycle where the phase is 3.
- R3: With bit 3 at 0, the timer advances once every 2^(P+1) source events, where P is bits 2:0. With bit 3 at 1, it advances on every source event.
- R4: A write with `wr_opt` at 0 loads `wr_data` into the timer on the next clock. That load overrides any increment due in the same cycle.
- R5: A timer write resets the divider to zero while bit 3 is 0. While bit 3 is 1, a timer write leaves the divider unchanged.
- R6: The watchdog base counter has WDT_W bits. It wraps every 2^WDT_W clocks. With bit 3 at 1, a reset fires on every 2^P-th wrap. With bit 3 at 0, a reset fires on every wrap. `wdt_rst` is high for one cycle, one clock after the wrap. `wdt_clr` zeroes the base counter and suppresses a reset in its own cycle. When bit 3 is 1, it also zeroes the divider.
- R7: With bit 5 at 1, the pin passes through SYNC_STAGES flip-flops and is XORed with bit 4 (1 selects the falling edge). It is sampled in phases 1 and 3. A source event occurs when a sample reads 1 and the previous sample read 0.
- R8: The overflow flag sets when an increment takes the timer from all ones to zero. It stays set until `flag_clr`. A set in the same cycle as a clear wins.
- R9: A write with `wr_opt` at 1 loads the option register. The new value takes effect from the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_opt | input | 1 | 1 selects the option register, 0 selects the timer |
| wr_data | input | TW | Write data |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog clear strobe |
| t_pin | input | 1 | External count input |
| tmr_q | output | TW | Timer value |
| opt_q | output | 8 | Option register |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The timer is driven from the instruction clock with ratios 1:2 and 1:16, and then with the divider taken away. Comparing these runs separates the prescaled path from the direct path. Repeated timer writes closer together than one ratio period show whether a write really restarts the divider. The watchdog runs at a postscale of 1:4, then with clear strobes closer together than its wrap period, then undivided. This separates the owner-dependent clear from the plain one. The pin is toggled for rising and falling edge selection, and finally at the minimum two-clock level width with no prescale, which exposes an off-by-one-phase sampling error.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
   localparam int RATIO_W = 3;
   localparam int DIV_W   = 1 << RATIO_W;

   typedef struct packed {
      logic [1:0]         spare;
      logic               ext_src;
      logic               fall_edge;
      logic               to_wdt;
      logic [RATIO_W-1:0] ratio;
   } opt_t;

   localparam logic [7:0] OPT_RESET = 8'hFF;
endpackage

// File: rtl/tsd_phase_sync.sv
module tsd_phase_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic       fall_edge,
   output logic [1:0] phase,
   output logic       instr_tick,
   output logic       ext_ev
);
   logic [SYNC_STAGES:0] chain;
   logic                 samp_q;
   logic                 lvl;
   logic                 sample_now;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 1..4");
   end

   assign chain[0] = pin;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b0;
         else        chain[i+1] <= chain[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= 2'd0;
      else        phase <= phase + 2'd1;
   end

   assign sample_now = phase[0];
   assign lvl        = chain[SYNC_STAGES] ^ fall_edge;
   assign instr_tick = (phase == 2'd3);
   assign ext_ev     = sample_now & lvl & ~samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          samp_q <= 1'b0;
      else if (sample_now) samp_q <= lvl;
   end

   p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> phase == $past(phase) + 2'd1);
   p_samp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_now && $past(rst_n)) |=> $stable(samp_q));
endmodule

// File: rtl/tsd_wdt.sv
module tsd_wdt #(
   parameter int WDT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic wrap
);
   logic [WDT_W-1:0] cnt_q;

   if (WDT_W < 2 || WDT_W > 24) begin : g_bad_w
      $error("WDT_W must be 2..24");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = &cnt_q;

   p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);
endmodule

// File: rtl/tsd_divider.sv
module tsd_divider #(
   parameter int RW = 3,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          to_wdt,
   input  logic [RW-1:0] ratio,
   input  logic          src_ev,
   input  logic          wdt_wrap,
   input  logic          tmr_wr,
   input  logic          wdt_clr,
   output logic          tmr_tick,
   output logic          wdt_fire
);
   localparam logic [DW-1:0] ONE = DW'(1);

   logic [DW-1:0] div_q, nxt, tmr_mask, wdt_mask;
   logic          clr, inc, tmr_hit, wdt_hit;

   if ((1 << RW) > DW) begin : g_bad_dw
      $error("divider too narrow for ratio field");
   end

   always_comb begin
      nxt      = div_q + ONE;
      tmr_mask = (ONE << ({1'b0, ratio} + {{RW{1'b0}}, 1'b1})) - ONE;
      wdt_mask = (ONE << ratio) - ONE;
      tmr_hit  = (nxt & tmr_mask) == '0;
      wdt_hit  = (nxt & wdt_mask) == '0;
      clr      = to_wdt ? wdt_clr  : tmr_wr;
      inc      = to_wdt ? wdt_wrap : src_ev;
      tmr_tick = to_wdt ? src_ev : (src_ev & tmr_hit);
      wdt_fire = ~wdt_clr & wdt_wrap & (~to_wdt | wdt_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (clr) div_q <= '0;
      else if (inc) div_q <= nxt;
   end

   p_div_clr_tmr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!to_wdt && tmr_wr) |=> div_q == '0);
   p_div_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (to_wdt && tmr_wr && !wdt_wrap && !wdt_clr) |=> $stable(div_q));
   p_div_clr_wdt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (to_wdt && wdt_clr) |=> div_q == '0);
endmodule

// File: rtl/tmr_shared_div.sv
module tmr_shared_div #(
   parameter int TW          = 8,
   parameter int WDT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_opt,
   input  logic [TW-1:0] wr_data,
   input  logic          flag_clr,
   input  logic          wdt_clr,
   input  logic          t_pin,
   output logic [TW-1:0] tmr_q,
   output logic [7:0]    opt_q,
   output logic          ovf_flag,
   output logic          wdt_rst
);
   import tsd_pkg::*;

   opt_t opt;
   logic tmr_wr, opt_wr;
   logic instr_tick, ext_ev, src_ev, wdt_wrap, tmr_tick, wdt_fire;
   logic [1:0] phase;

   if (TW < 8) begin : g_bad_tw
      $error("TW must be at least 8");
   end

   assign opt    = opt_t'(opt_q);
   assign tmr_wr = wr_en & ~wr_opt;
   assign opt_wr = wr_en &  wr_opt;

   tsd_phase_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(t_pin), .fall_edge(opt.fall_edge),
      .phase(phase), .instr_tick(instr_tick), .ext_ev(ext_ev));

   assign src_ev = opt.ext_src ? ext_ev : instr_tick;

   tsd_wdt #(.WDT_W(WDT_W)) u_wdt (
      .clk(clk), .rst_n(rst_n), .clr(wdt_clr), .wrap(wdt_wrap));

   tsd_divider #(.RW(RATIO_W), .DW(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .to_wdt(opt.to_wdt), .ratio(opt.ratio),
      .src_ev(src_ev), .wdt_wrap(wdt_wrap), .tmr_wr(tmr_wr),
      .wdt_clr(wdt_clr), .tmr_tick(tmr_tick), .wdt_fire(wdt_fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      opt_q <= OPT_RESET;
      else if (opt_wr) opt_q <= wr_data[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tmr_q <= '0;
      else if (tmr_wr)   tmr_q <= wr_data;
      else if (tmr_tick) tmr_q <= tmr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ovf_flag <= 1'b0;
      else if (tmr_tick && !tmr_wr && &tmr_q)   ovf_flag <= 1'b1;
      else if (flag_clr)                        ovf_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdt_rst <= 1'b0;
      else        wdt_rst <= wdt_fire;
   end

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_wr |=> tmr_q == $past(wr_data));
   p_opt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      opt_wr |=> opt_q == $past(wr_data[7:0]));
   p_flag_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> tmr_q == '0);
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr) |=> ovf_flag);
   p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst);
endmodule

// File: tb/test_tmr_shared_div.sv
module test_tmr_shared_div;
   localparam int WW = 4;
   localparam int SY = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_opt = 1'b0, flag_clr = 1'b0, wdt_clr = 1'b0, t_pin = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] tmr_q, opt_q;
   logic       ovf_flag, wdt_rst;

   tmr_shared_div #(.TW(8), .WDT_W(WW), .SYNC_STAGES(SY)) i_tmr_shared_div (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_opt(wr_opt), .wr_data(wr_data),
      .flag_clr(flag_clr), .wdt_clr(wdt_clr), .t_pin(t_pin),
      .tmr_q(tmr_q), .opt_q(opt_q), .ovf_flag(ovf_flag), .wdt_rst(wdt_rst));

   int checks = 0, errors = 0;
   string tag = "R1";
   bit done = 0;

   // behavioural reference state
   int m_q, m_samp, m_div, m_w, m_tmr, m_flag, m_rst, m_opt;
   int m_hist[SY];

   always @(posedge clk) begin
      int ps, psa, fall, ext, lvl, ev_ext, src, wov, twr, tick, fire, clr, inc;
      if (!rst_n) begin
         m_q = 0; m_samp = 0; m_div = 0; m_w = 0; m_tmr = 0; m_flag = 0;
         m_rst = 0; m_opt = 255;
         for (int i = 0; i < SY; i++) m_hist[i] = 0;
      end else begin
         ps = m_opt % 8; psa = (m_opt / 8) % 2; fall = (m_opt / 16) % 2; ext = (m_opt / 32) % 2;
         lvl    = (m_hist[SY-1] != fall) ? 1 : 0;
         ev_ext = (m_q % 2 == 1 && lvl == 1 && m_samp == 0) ? 1 : 0;
         if (m_q % 2 == 1) m_samp = lvl;
         for (int i = SY - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
         m_hist[0] = int'(t_pin);
         src  = ext ? ev_ext : ((m_q == 3) ? 1 : 0);
         wov  = (m_w == (1 << WW) - 1) ? 1 : 0;
         twr  = (wr_en && !wr_opt) ? 1 : 0;
         if (psa == 0) begin
            tick = (src == 1 && ((m_div + 1) % (2 << ps)) == 0) ? 1 : 0;
            fire = (wov == 1 && !wdt_clr) ? 1 : 0;
            clr = twr; inc = src;
         end else begin
            tick = src;
            fire = (wov == 1 && !wdt_clr && ((m_div + 1) % (1 << ps)) == 0) ? 1 : 0;
            clr = int'(wdt_clr); inc = wov;
         end
         if (clr == 1)      m_div = 0;
         else if (inc == 1) m_div = (m_div + 1) % 256;
         m_w   = wdt_clr ? 0 : (m_w + 1) % (1 << WW);
         m_rst = fire;
         if (tick == 1 && twr == 0 && m_tmr == 255) m_flag = 1;
         else if (flag_clr)                         m_flag = 0;
         if (twr == 1)       m_tmr = int'(wr_data);
         else if (tick == 1) m_tmr = (m_tmr + 1) % 256;
         if (wr_en && wr_opt) m_opt = int'(wr_data);
         m_q = (m_q + 1) % 4;
      end
   end

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every clock, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(tmr_q),    m_tmr,  "timer (R3/R4)");
         chk(int'(opt_q),    m_opt,  "option (R9)");
         chk(int'(ovf_flag), m_flag, "flag (R8)");
         chk(int'(wdt_rst),  m_rst,  "wdt_rst (R6)");
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input bit sel, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_opt = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_opt = 1'b0;
   endtask

   task automatic pulse_wdt_clr();
      @(negedge clk); wdt_clr = 1'b1;
      @(negedge clk); wdt_clr = 1'b0;
   endtask

   task automatic toggle_pin(input int n, input int half);
      for (int k = 0; k < n; k++) begin
         run(half);
         t_pin = ~t_pin;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      run(4);
      rst_n = 1'b1;
      // R1: reset values
      tag = "R1";
      @(negedge clk);
      chk(int'(opt_q), 255, "R1 option reset");
      chk(int'(tmr_q), 0, "R1 timer reset");
      chk(int'(ovf_flag), 0, "R1 flag reset");
      chk(int'(wdt_rst), 0, "R1 wdt_rst reset");
      // R9 and R2: instruction clock, ratio 1:2
      tag = "R9"; wr(1'b1, 8'h00);
      tag = "R2"; run(60);
      // R3: ratio 1:16, then divider handed to watchdog (direct timer)
      tag = "R3"; wr(1'b0, 8'h00); wr(1'b1, 8'h03); run(200);
      pulse_wdt_clr(); wr(1'b1, 8'h0B); run(60);
      // R4 and R8: preload near wrap, overflow, clear flag
      tag = "R4"; wr(1'b0, 8'hFD); run(20);
      tag = "R8"; run(10);
      @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      run(10);
      // R5: divider owned by timer, writes faster than the 1:8 ratio
      tag = "R5"; pulse_wdt_clr(); wr(1'b1, 8'h02);
      for (int k = 0; k < 6; k++) begin wr(1'b0, 8'h10); run(18); end
      run(80);
      // R5: divider owned by watchdog, timer writes do not clear it
      wr(1'b1, 8'h0A);
      for (int k = 0; k < 4; k++) begin wr(1'b0, 8'h40); run(14); end
      // R6: postscale 1:4, frequent clears, then undivided watchdog
      tag = "R6"; run(150);
      for (int k = 0; k < 12; k++) begin pulse_wdt_clr(); run(8); end
      wr(1'b1, 8'h00); run(50);
      // R7: external pin, rising, falling, then minimum level width
      tag = "R7"; wr(1'b1, 8'h20); toggle_pin(30, 3);
      wr(1'b1, 8'h30); toggle_pin(30, 5);
      pulse_wdt_clr(); wr(1'b1, 8'h28); toggle_pin(40, 2);
      run(10);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule